// File: doc/BRIEF.md
# Wireless Coexistence Slot Arbiter

This block sits between a WLAN core and an external Bluetooth radio and decides, slot by slot, whether the Bluetooth side may use the shared medium. The Bluetooth radio raises a request line for each transmit or receive slot it wants. In three-wire mode it also presents a priority line. The arbiter answers on a deny line, where high means the Bluetooth slot is blocked. A separate antenna-switch output lets the WLAN core steer the antenna directly, outside the arbitration.

The WLAN core supplies a busy flag and a high-priority flag. In two-wire mode any WLAN activity blocks Bluetooth. In three-wire mode a high-priority Bluetooth packet overrides normal-priority WLAN traffic, but it still loses to high-priority WLAN traffic. The decision is taken once, when a request begins, and it stays fixed for the rest of that slot.

The four signals (request, priority, deny and antenna) travel over a bank of general-purpose pins. Each signal has its own enable bit and pin-index field, so any signal can sit on any pin. Pins that carry no output signal are released. A map that places two signals on one pin, or that points at a pin which does not exist, raises a configuration error flag.

Top module: `coex_arbiter`

## Requirements
- R1: Signal slots in `map_en`/`map_pin` are: 0 request (input), 1 priority (input), 2 deny (output), 3 antenna (output). Slot f uses `map_en[f]` and `map_pin[f*PIN_W +: PIN_W]`, with PIN_W = 3 at the default of 7 pins. A pin that carries no enabled output signal with a valid index has `pin_oe`=0 and `pin_out`=0.
- R2: An enabled output signal with a valid index drives its pin with `pin_oe`=1 in the same cycle the map is applied. If deny and antenna share a pin, the deny value is the one driven.
- R3: Request and priority are read from their mapped pins and registered once. A signal that is disabled, or that has an index of NUM_PINS or more, reads as 0.
- R4: While the registered request is low, deny takes the value `wl_busy` had at the previous clock edge.
- R5: In two-wire mode (`mode_3wire`=0), the deny level latched when a request starts equals `wl_busy`, whatever the priority pin shows.
- R6: In three-wire mode, the deny level latched at request start is 0 when Bluetooth priority is high and `wl_hi_pri` is low. It is `wl_busy` otherwise, so high-priority WLAN wins.
- R7: Once decided, deny holds for as long as the registered request stays high. Changes on the priority pin, `wl_busy` or `wl_hi_pri` during the slot have no effect.
- R8: `cfg_error` goes high one cycle after a map in which two enabled signals share a pin index, or in which an enabled signal has an index of NUM_PINS or more. It goes low one cycle after the map is corrected.
- R9: The antenna output equals `ant_sw_req` delayed by one clock, independent of requests and deny.
- R10: While `rst` is high, deny, antenna and `cfg_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_3wire | input | 1 | 1 selects three-wire mode with Bluetooth priority |
| wl_busy | input | 1 | WLAN core is using the medium |
| wl_hi_pri | input | 1 | WLAN traffic is high priority |
| ant_sw_req | input | 1 | Direct antenna-switch level from the WLAN core |
| map_en | input | 4 | Per-signal enable, indexed by signal slot |
| map_pin | input | 4*PIN_W | Per-signal pin index fields |
| pin_in | input | NUM_PINS | Levels read from the general-purpose pins |
| pin_out | output | NUM_PINS | Levels driven onto the pins |
| pin_oe | output | NUM_PINS | Output enable per pin |
| cfg_error | output | 1 | Pin map conflict or invalid index |

## Verification
Two functions that can land on the same cycle are the start of a slot decision and a change in WLAN busy or priority. Another such pair is a collision of the deny and antenna outputs on one pin. The bench raises the request in the same cycle that it flips `wl_busy`, `wl_hi_pri` or the priority pin, and then judges whether the latched deny matches the value in force at request start. It also maps deny and antenna onto one pin while their levels differ, and checks that the pin shows deny and that the error flag rises a cycle later. A behavioural per-cycle model compares every pin and the error flag after each clock.

// File: rtl/coex_pkg.sv
package coex_pkg;

    localparam int FN_CNT = 4;

    typedef enum logic [1:0] {
        FN_REQ  = 2'd0,
        FN_PRI  = 2'd1,
        FN_DENY = 2'd2,
        FN_ANT  = 2'd3
    } coex_fn_e;

    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_HELD = 1'b1
    } slot_e;

    typedef struct packed {
        logic req;
        logic pri;
    } bt_in_t;

    typedef struct packed {
        logic deny;
        logic ant;
    } coex_out_t;

    function automatic int idx_width(input int npins);
        return (npins > 1) ? $clog2(npins) : 1;
    endfunction

endpackage

// File: rtl/coex_pin_sampler.sv
module coex_pin_sampler
    import coex_pkg::*;
#(
    parameter int NUM_PINS = 7,
    localparam int PIN_W = idx_width(NUM_PINS)
)(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [1:0]            in_en,
    input  logic [2*PIN_W-1:0]    in_pin,
    input  logic [NUM_PINS-1:0]   pin_in,
    output bt_in_t                bt
);

    logic [1:0] picked;

    for (genvar f = 0; f < 2; f++) begin : g_in
        logic [PIN_W-1:0] fld;
        assign fld = in_pin[f*PIN_W +: PIN_W];
        always_comb begin
            picked[f] = 1'b0;
            for (int p = 0; p < NUM_PINS; p++) begin
                if (in_en[f] && (fld == PIN_W'(p)))
                    picked[f] = pin_in[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bt <= '0;
        end else begin
            bt.req <= picked[0];
            bt.pri <= picked[1];
        end
    end

endmodule

// File: rtl/coex_decider.sv
module coex_decider
    import coex_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      mode_3wire,
    input  logic      wl_busy,
    input  logic      wl_hi_pri,
    input  logic      ant_sw_req,
    input  bt_in_t    bt,
    output coex_out_t res
);

    slot_e slot_q;
    logic  bt_wins;

    assign bt_wins = mode_3wire && bt.pri && !wl_hi_pri;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= SLOT_IDLE;
            res    <= '0;
        end else begin
            res.ant <= ant_sw_req;
            if (bt.req) begin
                if (slot_q == SLOT_IDLE) begin
                    res.deny <= wl_busy && !bt_wins;
                    slot_q   <= SLOT_HELD;
                end
            end else begin
                res.deny <= wl_busy;
                slot_q   <= SLOT_IDLE;
            end
        end
    end

    assert_idle_follow_R4: assert property (@(posedge clk) disable iff (rst)
        !bt.req |=> (res.deny == $past(wl_busy)));

    assert_two_wire_R5: assert property (@(posedge clk) disable iff (rst)
        (bt.req && slot_q == SLOT_IDLE && !mode_3wire) |=> (res.deny == $past(wl_busy)));

    assert_bt_pri_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (bt.req && slot_q == SLOT_IDLE && mode_3wire && bt.pri && !wl_hi_pri) |=> !res.deny);

    assert_slot_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (bt.req && slot_q == SLOT_HELD) |=> $stable(res.deny));

    assert_ant_bypass_R9: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (res.ant == $past(ant_sw_req)));

endmodule

// File: rtl/coex_pin_driver.sv
module coex_pin_driver
    import coex_pkg::*;
#(
    parameter int NUM_PINS = 7,
    localparam int PIN_W = idx_width(NUM_PINS)
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           out_en,
    input  logic [2*PIN_W-1:0]   out_pin,
    input  coex_out_t            res,
    output logic [NUM_PINS-1:0]  pin_out,
    output logic [NUM_PINS-1:0]  pin_oe
);

    logic [PIN_W-1:0] deny_fld, ant_fld;
    assign deny_fld = out_pin[0 +: PIN_W];
    assign ant_fld  = out_pin[PIN_W +: PIN_W];

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic deny_hit, ant_hit;
        assign deny_hit = out_en[0] && (deny_fld == PIN_W'(p));
        assign ant_hit  = out_en[1] && (ant_fld == PIN_W'(p));
        always_comb begin
            pin_oe[p]  = deny_hit || ant_hit;
            if (deny_hit)      pin_out[p] = res.deny;
            else if (ant_hit)  pin_out[p] = res.ant;
            else               pin_out[p] = 1'b0;
        end
    end

    assert_released_low_R1: assert property (@(posedge clk) disable iff (rst)
        ((pin_out & ~pin_oe) == '0));

    assert_oe_count_R2: assert property (@(posedge clk) disable iff (rst)
        ($countones(pin_oe) <= 2));

endmodule

// File: rtl/coex_map_check.sv
module coex_map_check
    import coex_pkg::*;
#(
    parameter int NUM_PINS = 7,
    localparam int PIN_W = idx_width(NUM_PINS)
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [FN_CNT-1:0]         map_en,
    input  logic [FN_CNT*PIN_W-1:0]   map_pin,
    output logic                      cfg_error
);

    logic [PIN_W-1:0] fld [FN_CNT];
    logic [FN_CNT-1:0] bad_idx;
    logic clash;

    for (genvar f = 0; f < FN_CNT; f++) begin : g_fld
        assign fld[f]     = map_pin[f*PIN_W +: PIN_W];
        assign bad_idx[f] = map_en[f] && (int'(fld[f]) >= NUM_PINS);
    end

    always_comb begin
        clash = 1'b0;
        for (int i = 0; i < FN_CNT; i++)
            for (int j = i + 1; j < FN_CNT; j++)
                if (map_en[i] && map_en[j] && (fld[i] == fld[j]))
                    clash = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_error <= 1'b0;
        else     cfg_error <= clash || (|bad_idx);
    end

    assert_out_clash_R8: assert property (@(posedge clk) disable iff (rst)
        (map_en[FN_DENY] && map_en[FN_ANT] && fld[FN_DENY] == fld[FN_ANT]) |=> cfg_error);

endmodule

// File: rtl/coex_arbiter.sv
module coex_arbiter
    import coex_pkg::*;
#(
    parameter int NUM_PINS = 7,
    localparam int PIN_W = idx_width(NUM_PINS)
)(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      mode_3wire,
    input  logic                      wl_busy,
    input  logic                      wl_hi_pri,
    input  logic                      ant_sw_req,
    input  logic [FN_CNT-1:0]         map_en,
    input  logic [FN_CNT*PIN_W-1:0]   map_pin,
    input  logic [NUM_PINS-1:0]       pin_in,
    output logic [NUM_PINS-1:0]       pin_out,
    output logic [NUM_PINS-1:0]       pin_oe,
    output logic                      cfg_error
);

    bt_in_t    bt;
    coex_out_t res;

    coex_pin_sampler #(.NUM_PINS(NUM_PINS)) u_sampler (
        .clk    (clk),
        .rst    (rst),
        .in_en  (map_en[1:0]),
        .in_pin (map_pin[2*PIN_W-1:0]),
        .pin_in (pin_in),
        .bt     (bt)
    );

    coex_decider u_decider (
        .clk        (clk),
        .rst        (rst),
        .mode_3wire (mode_3wire),
        .wl_busy    (wl_busy),
        .wl_hi_pri  (wl_hi_pri),
        .ant_sw_req (ant_sw_req),
        .bt         (bt),
        .res        (res)
    );

    coex_pin_driver #(.NUM_PINS(NUM_PINS)) u_driver (
        .clk     (clk),
        .rst     (rst),
        .out_en  (map_en[3:2]),
        .out_pin (map_pin[FN_CNT*PIN_W-1:2*PIN_W]),
        .res     (res),
        .pin_out (pin_out),
        .pin_oe  (pin_oe)
    );

    coex_map_check #(.NUM_PINS(NUM_PINS)) u_check (
        .clk       (clk),
        .rst       (rst),
        .map_en    (map_en),
        .map_pin   (map_pin),
        .cfg_error (cfg_error)
    );

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (!cfg_error && !res.deny && !res.ant));

endmodule

// File: tb/coex_arbiter_test.sv
module coex_arbiter_test;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 7;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_3wire = 1'b0, wl_busy = 1'b0, wl_hi_pri = 1'b0, ant_sw_req = 1'b0;
    logic [3:0]      map_en = 4'b1111;
    logic [4*PW-1:0] map_pin = {3'd0, 3'd4, 3'd3, 3'd2};
    logic [NP-1:0]   pin_in = '0;
    logic [NP-1:0]   pin_out, pin_oe;
    logic            cfg_error;

    int checks = 0, fails = 0;
    bit finished = 0;
    string cur_req = "R10";

    // behavioural model state
    bit m_req, m_pri, m_slot, m_deny, m_ant, m_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    coex_arbiter uut (
        .clk(clk), .rst(rst), .mode_3wire(mode_3wire), .wl_busy(wl_busy),
        .wl_hi_pri(wl_hi_pri), .ant_sw_req(ant_sw_req), .map_en(map_en),
        .map_pin(map_pin), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
        .cfg_error(cfg_error)
    );

    function automatic int fld(input int f);
        return int'(map_pin[f*PW +: PW]);
    endfunction

    function automatic bit mread(input int f);
        if (map_en[f] && fld(f) < NP) return pin_in[fld(f)];
        return 1'b0;
    endfunction

    function automatic bit map_bad();
        for (int i = 0; i < 4; i++) begin
            if (map_en[i] && fld(i) >= NP) return 1'b1;
            for (int j = i + 1; j < 4; j++)
                if (map_en[i] && map_en[j] && fld(i) == fld(j)) return 1'b1;
        end
        return 1'b0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_req = 0; m_pri = 0; m_slot = 0; m_deny = 0; m_ant = 0; m_err = 0;
        end else begin
            if (m_req) begin
                if (!m_slot) begin
                    m_deny = wl_busy && !(mode_3wire && m_pri && !wl_hi_pri);
                    m_slot = 1;
                end
            end else begin
                m_deny = wl_busy;
                m_slot = 0;
            end
            m_ant = ant_sw_req;
            m_err = map_bad();
            m_req = mread(0);
            m_pri = mread(1);
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic model_compare();
        logic [NP-1:0] e_out = '0, e_oe = '0;
        for (int p = 0; p < NP; p++) begin
            if (map_en[2] && fld(2) == p) begin e_oe[p] = 1; e_out[p] = m_deny; end
            else if (map_en[3] && fld(3) == p) begin e_oe[p] = 1; e_out[p] = m_ant; end
        end
        check({cur_req, " pin_oe"}, 32'(pin_oe), 32'(e_oe));
        check({cur_req, " pin_out"}, 32'(pin_out), 32'(e_out));
        check({cur_req, " cfg_error"}, 32'(cfg_error), 32'(m_err));
    endtask

    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD/4);
        model_compare();
    endtask

    task automatic step2();
        step(); step();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; fails++;
        $display("FAIL watchdog: actual running expected done");
        finish_run();
    end

    initial begin
        // reset: pins 2 req, 3 pri, 4 deny, 0 antenna
        repeat (3) step();
        check("R10 deny in reset", 32'(pin_out[4]), 0);
        check("R10 cfg_error in reset", 32'(cfg_error), 0);
        check("R1 only mapped outputs enabled", 32'(pin_oe), 32'(7'b0010001));
        rst = 0;

        cur_req = "R4";
        wl_busy = 1; step();
        check("R4 idle deny follows busy", 32'(pin_out[4]), 1);
        wl_busy = 0; step();
        check("R4 idle deny follows idle", 32'(pin_out[4]), 0);

        cur_req = "R5";
        mode_3wire = 0; wl_busy = 1; pin_in[3] = 1; pin_in[2] = 1; step2();
        check("R5 two-wire busy denies despite priority", 32'(pin_out[4]), 1);
        cur_req = "R7";
        wl_busy = 0; step();
        check("R7 held through busy drop", 32'(pin_out[4]), 1);
        pin_in[2] = 0; step2();
        check("R4 release follows busy", 32'(pin_out[4]), 0);

        pin_in[2] = 1; step2();
        check("R5 two-wire idle grants", 32'(pin_out[4]), 0);
        wl_busy = 1; wl_hi_pri = 1; step2();
        check("R7 grant held through busy rise", 32'(pin_out[4]), 0);
        pin_in[2] = 0; wl_hi_pri = 0; step2();

        cur_req = "R6";
        mode_3wire = 1; pin_in[3] = 1; pin_in[2] = 1; step2();
        check("R6 high-pri bluetooth beats normal wlan", 32'(pin_out[4]), 0);
        cur_req = "R9";
        pin_in[3] = 0; ant_sw_req = 1; step();
        check("R9 antenna follows request", 32'(pin_out[0]), 1);
        check("R7 priority drop ignored in slot", 32'(pin_out[4]), 0);
        pin_in[2] = 0; step2();
        check("R4 deny back to busy", 32'(pin_out[4]), 1);

        cur_req = "R6";
        wl_hi_pri = 1; pin_in[3] = 1; pin_in[2] = 1; step2();
        check("R6 high-pri wlan beats bluetooth", 32'(pin_out[4]), 1);
        pin_in[2] = 0; wl_hi_pri = 0; pin_in[3] = 0; step2();
        pin_in[2] = 1; step2();
        check("R6 normal bluetooth loses to busy wlan", 32'(pin_out[4]), 1);
        pin_in[2] = 0; ant_sw_req = 0; step2();
        check("R9 antenna low", 32'(pin_out[0]), 0);

        cur_req = "R3";
        map_en[1] = 0; pin_in[3] = 1; pin_in[2] = 1; step2();
        check("R3 disabled priority reads low", 32'(pin_out[4]), 1);
        pin_in[2] = 0; map_en[1] = 1; pin_in[3] = 0; step2();
        map_pin[0 +: PW] = 3'd5; pin_in[2] = 1; wl_busy = 1; step2();
        wl_busy = 0; step();
        check("R3 old request pin ignored", 32'(pin_out[4]), 0);
        pin_in[2] = 0; wl_busy = 1; pin_in[5] = 1; step2();
        wl_busy = 0; step();
        check("R3 request read on new pin", 32'(pin_out[4]), 1);
        pin_in[5] = 0; step2();

        cur_req = "R8";
        wl_busy = 1; ant_sw_req = 0; step();
        map_pin[3*PW +: PW] = 3'd4; step();
        check("R8 output clash flagged", 32'(cfg_error), 1);
        check("R2 deny wins shared pin", 32'(pin_out[4]), 1);
        check("R1 freed antenna pin released", 32'(pin_oe), 32'(7'b0010000));
        map_pin[3*PW +: PW] = 3'd0; step();
        check("R8 clash cleared", 32'(cfg_error), 0);
        map_pin[2*PW +: PW] = 3'd7; step();
        check("R8 invalid index flagged", 32'(cfg_error), 1);
        check("R1 invalid index drives nothing", 32'(pin_oe), 32'(7'b0000001));
        map_pin[2*PW +: PW] = 3'd4; map_pin[0 +: PW] = 3'd3; step();
        check("R8 input clash flagged", 32'(cfg_error), 1);
        map_pin[0 +: PW] = 3'd2; step();
        check("R8 restored map clean", 32'(cfg_error), 0);

        cur_req = "R10";
        ant_sw_req = 1; rst = 1; step();
        check("R10 reset clears antenna", 32'(pin_out[0]), 0);
        check("R10 reset clears deny", 32'(pin_out[4]), 0);
        rst = 0; step();

        finish_run();
    end

endmodule